// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a system that must prove it is alive at regular intervals. A down-counter is loaded from a programmable reload register and decremented on every tick of a programmable prescaler. If software lets the count run out, the block raises a one-cycle reset request. After that it reloads and keeps counting until an external reset clears it. The whole block runs from a single clock.

Software reaches the block only through a narrow write port with three addresses: a key register (address 0), a divider-select register (address 1) and a reload register (address 2). Control does not use plain enable bits. It uses four 16-bit key values. Key 0x5555 opens the divider-select and reload registers for writing. Key 0xAAAA reloads the count ("feed"). Key 0xCCCC starts the countdown. Any other key value closes write access again. Once started, the watchdog cannot be stopped by any write.

The control state machine has four states. HALT_LOCKED is the reset state. HALT_OPEN is entered from either halted state with 0x5555. RUN_LOCKED is entered from either halted state with 0xCCCC, and from RUN_OPEN with any key other than 0x5555. RUN_OPEN is entered from either running state with 0x5555. A halted state returns to HALT_LOCKED on 0xAAAA or on an unrecognised key. Neither running state ever leads back to a halted state.

Top module: `guard_wdt`

## Requirements
- R1: After reset no request is raised. The divider select is 0 and the reload value is 0xFFF, so a start with no configuration fires 16380 clock edges after the start write.
- R2: A write to the divider select (address 1) or to the reload register (address 2) has no effect while write access is closed.
- R3: A key write of 0x5555 (address 0) opens write access. Later writes to address 1 (data bits 2:0) and to address 2 (data bits 11:0) then take effect.
- R4: A key write of 0xCCCC starts the countdown from the reload value R. With no further key writes, the request is high in the cycle after clock edge max(R,1)·D, counted from the start write edge, where D is the selected divide.
- R5: A key write of 0xAAAA reloads the count and restarts the divide phase. While feeds keep coming, no request is raised, and the next request comes max(R,1)·D edges after the last feed.
- R6: Divider select codes 0 to 6 give a divide of 4·2^code (4, 8, … 256), and code 7 also gives 256.
- R7: Any key value other than 0x5555 closes write access, and this includes 0xAAAA and 0xCCCC.
- R8: Once started, the watchdog keeps running whatever key or register writes follow. An unlock key does not restart the countdown.
- R9: The request lasts exactly one cycle. The count then reloads, so with no feed the requests repeat every max(R,1)·D edges.
- R10: Before a start, no request is raised, and this holds even after feed keys.
- R11: A reload value of 0 expires on the first prescaler tick, that is D edges after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the dedicated low-speed clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | 0 key, 1 divider select, 2 reload |
| wr_data | input | 16 | Write data |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The countdown is timed edge by edge under several patterns. These are an unconfigured start, every divider code with a short reload, a zero reload, and a feed train followed by silence. Together they separate a wrong divide, a count that is off by one, and a feed that fails to restart the prescaler phase. The protection tests write new values while access is closed, or after a key that should have closed it. Each then compares the resulting timeout against the old and the new setting, so an ignored write is told apart from an accepted one. The locking tests send stop-like keys and an unlock key to a running watchdog, then check that the first request still arrives on the original schedule and that the next period repeats unchanged.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;

    localparam int ADDR_W = 2;
    localparam int KEY_W  = 16;

    localparam logic [ADDR_W-1:0] ADDR_KEY = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIV = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RLD = 2'd2;

    localparam logic [KEY_W-1:0] KEY_OPEN = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_FEED = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_GO   = 16'hCCCC;

    typedef enum logic [1:0] {
        ST_HALT_LOCKED,
        ST_HALT_OPEN,
        ST_RUN_LOCKED,
        ST_RUN_OPEN
    } wdt_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_OPEN,
        CMD_FEED,
        CMD_GO,
        CMD_OTHER
    } wdt_cmd_e;

endpackage

// File: rtl/guard_wdt_ctrl.sv
module guard_wdt_ctrl
    import guard_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output logic             cfg_open,
    output logic             running,
    output logic             load
);

    wdt_state_e state_q, state_d;
    wdt_cmd_e   cmd;

    // key decode
    always_comb begin
        if (!key_wr)                 cmd = CMD_NONE;
        else if (key_val == KEY_OPEN) cmd = CMD_OPEN;
        else if (key_val == KEY_FEED) cmd = CMD_FEED;
        else if (key_val == KEY_GO)   cmd = CMD_GO;
        else                          cmd = CMD_OTHER;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT_LOCKED: begin
                if (cmd == CMD_OPEN)    state_d = ST_HALT_OPEN;
                else if (cmd == CMD_GO) state_d = ST_RUN_LOCKED;
            end
            ST_HALT_OPEN: begin
                if (cmd == CMD_GO)                              state_d = ST_RUN_LOCKED;
                else if (cmd == CMD_FEED || cmd == CMD_OTHER)   state_d = ST_HALT_LOCKED;
            end
            ST_RUN_LOCKED: begin
                if (cmd == CMD_OPEN) state_d = ST_RUN_OPEN;
            end
            ST_RUN_OPEN: begin
                if (cmd != CMD_OPEN && cmd != CMD_NONE) state_d = ST_RUN_LOCKED;
            end
            default: state_d = ST_HALT_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT_LOCKED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cfg_open = 1'b0;
        running  = 1'b0;
        unique case (state_q)
            ST_HALT_LOCKED: ;
            ST_HALT_OPEN:   cfg_open = 1'b1;
            ST_RUN_LOCKED:  running  = 1'b1;
            ST_RUN_OPEN: begin
                running  = 1'b1;
                cfg_open = 1'b1;
            end
            default: ;
        endcase
        load = (cmd == CMD_FEED) || (cmd == CMD_GO);
    end

endmodule

// File: rtl/guard_wdt_regs.sv
module guard_wdt_regs
    import guard_wdt_pkg::*;
#(
    parameter int DIV_SEL_W = 3,
    parameter int RLD_W     = 12,
    parameter int RLD_INIT  = 4095
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DIV_SEL_W-1:0] div_data,
    input  logic [RLD_W-1:0]     rld_data,
    input  logic                 cfg_open,
    output logic [DIV_SEL_W-1:0] div_sel,
    output logic [RLD_W-1:0]     reload
);

    logic div_we, rld_we;

    assign div_we = wr_en && cfg_open && (wr_addr == ADDR_DIV);
    assign rld_we = wr_en && cfg_open && (wr_addr == ADDR_RLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_sel <= '0;
            reload  <= RLD_W'(RLD_INIT);
        end else begin
            if (div_we) div_sel <= div_data;
            if (rld_we) reload  <= rld_data;
        end
    end

endmodule

// File: rtl/guard_wdt_presc.sv
module guard_wdt_presc #(
    parameter int DIV_SEL_W   = 3,
    parameter int PRE_MIN_LOG = 2,
    parameter int PRE_CODES   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 running,
    input  logic                 restart,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);

    localparam int PRE_MAX_LOG = PRE_MIN_LOG + PRE_CODES - 1;
    localparam int CNT_W       = PRE_MAX_LOG;
    localparam int N_SEL       = 1 << DIV_SEL_W;

    logic [CNT_W-1:0] lim [N_SEL];
    logic [CNT_W-1:0] pc_q;
    logic [CNT_W-1:0] lim_sel;

    // terminal count per select code; codes past the last saturate
    for (genvar i = 0; i < N_SEL; i++) begin : g_lim
        localparam int SH = (PRE_MIN_LOG + i > PRE_MAX_LOG) ? PRE_MAX_LOG : PRE_MIN_LOG + i;
        assign lim[i] = CNT_W'((64'd1 << SH) - 64'd1);
    end

    assign lim_sel = lim[div_sel];
    assign tick    = running && !restart && (pc_q == lim_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pc_q <= '0;
        else if (!running || restart) pc_q <= '0;
        else if (pc_q == lim_sel)     pc_q <= '0;
        else                          pc_q <= pc_q + 1'b1;
    end

endmodule

// File: rtl/guard_wdt_count.sv
module guard_wdt_count #(
    parameter int RLD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             load,
    input  logic             tick,
    input  logic [RLD_W-1:0] reload,
    output logic             rst_req
);

    logic [RLD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (load) begin
                cnt_q <= reload;
            end else if (running && tick) begin
                if (cnt_q <= RLD_W'(1)) begin
                    cnt_q   <= reload;
                    rst_req <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
    import guard_wdt_pkg::*;
#(
    parameter int DIV_SEL_W   = 3,
    parameter int RLD_W       = 12,
    parameter int RLD_INIT    = 4095,
    parameter int PRE_MIN_LOG = 2,
    parameter int PRE_CODES   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    output logic              rst_req
);

    logic                 cfg_open;
    logic                 running;
    logic                 load;
    logic                 tick;
    logic [DIV_SEL_W-1:0] div_sel;
    logic [RLD_W-1:0]     reload_val;
    logic                 key_wr;

    assign key_wr = wr_en && (wr_addr == ADDR_KEY);

    guard_wdt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_val  (wr_data),
        .cfg_open (cfg_open),
        .running  (running),
        .load     (load)
    );

    guard_wdt_regs #(
        .DIV_SEL_W (DIV_SEL_W),
        .RLD_W     (RLD_W),
        .RLD_INIT  (RLD_INIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .div_data (wr_data[DIV_SEL_W-1:0]),
        .rld_data (wr_data[RLD_W-1:0]),
        .cfg_open (cfg_open),
        .div_sel  (div_sel),
        .reload   (reload_val)
    );

    guard_wdt_presc #(
        .DIV_SEL_W   (DIV_SEL_W),
        .PRE_MIN_LOG (PRE_MIN_LOG),
        .PRE_CODES   (PRE_CODES)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .restart (load),
        .div_sel (div_sel),
        .tick    (tick)
    );

    guard_wdt_count #(
        .RLD_W (RLD_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .load    (load),
        .tick    (tick),
        .reload  (reload_val),
        .rst_req (rst_req)
    );

endmodule

// File: rtl/guard_wdt_chk.sv
module guard_wdt_chk
    import guard_wdt_pkg::*;
#(
    parameter int DIV_SEL_W = 3,
    parameter int RLD_W     = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [KEY_W-1:0]     wr_data,
    input logic                 rst_req,
    input logic                 running,
    input logic                 cfg_open,
    input logic [DIV_SEL_W-1:0] div_sel,
    input logic [RLD_W-1:0]     reload
);

    logic key_wr;
    assign key_wr = wr_en && (wr_addr == ADDR_KEY);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !rst_req);

    assert_run_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_feed_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data == KEY_FEED) |=> !rst_req);

    assert_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data == KEY_OPEN) |=> cfg_open);

    assert_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data != KEY_OPEN) |=> !cfg_open);

    assert_locked_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DIV && !cfg_open) |=> $stable(div_sel));

    assert_locked_rld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RLD && !cfg_open) |=> $stable(reload));

endmodule

bind guard_wdt guard_wdt_chk #(
    .DIV_SEL_W (DIV_SEL_W),
    .RLD_W     (RLD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rst_req  (rst_req),
    .running  (running),
    .cfg_open (cfg_open),
    .div_sel  (div_sel),
    .reload   (reload_val)
);

// File: tb/test_guard_wdt.sv
`timescale 1ns/1ps
module test_guard_wdt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    guard_wdt i_guard_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rst_req (rst_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // edges after the last write edge until rst_req is seen; -1 if none
    task automatic wait_pulse(input int limit, output int n);
        bit found = 0;
        n = 0;
        while (n < limit && !found) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (rst_req) found = 1;
        end
        if (!found) n = -1;
    endtask

    task automatic t_reset_state();
        int n;
        do_reset();
        @(negedge clk);
        check(rst_req == 1'b0, "R1 idle after reset", rst_req, 0);
        wr(2'd0, 16'hCCCC);
        wait_pulse(20000, n);
        check(n == 16380, "R1 default timeout", n, 16380);
    endtask

    task automatic t_idle();
        int n;
        do_reset();
        wr(2'd0, 16'hAAAA);
        wait_pulse(600, n);
        check(n == -1, "R10 no request before start", n, -1);
    endtask

    task automatic t_unlock_start();
        int n;
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd6);
        wr(2'd0, 16'hCCCC);
        wait_pulse(2000, n);
        check(n == 48, "R3 R4 configured timeout", n, 48);
    endtask

    task automatic t_locked_writes();
        int n;
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd10);
        wr(2'd0, 16'hAAAA);
        wr(2'd2, 16'd3);
        wr(2'd1, 16'd2);
        wr(2'd0, 16'hCCCC);
        wait_pulse(2000, n);
        check(n == 40, "R2 locked writes ignored", n, 40);
    endtask

    task automatic t_codes();
        for (int code = 0; code < 8; code++) begin
            int n;
            int dv;
            dv = (code >= 6) ? 256 : (4 << code);
            do_reset();
            wr(2'd0, 16'h5555);
            wr(2'd1, 16'(code));
            wr(2'd2, 16'd2);
            wr(2'd0, 16'hCCCC);
            wait_pulse(2000, n);
            check(n == 2 * dv, $sformatf("R6 divide code %0d", code), n, 2 * dv);
        end
    endtask

    task automatic t_other_key();
        int n;
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd5);
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'hCCCC);
        wait_pulse(2000, n);
        check(n == 20, "R7 stray key closes access", n, 20);
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd5);
        wr(2'd0, 16'hCCCC);
        wr(2'd2, 16'd2);
        wait_pulse(2000, n);
        check(n == 19, "R7 start key closes access", n, 19);
        wait_pulse(2000, n);
        check(n == 20, "R7 reload kept after start", n, 20);
    endtask

    task automatic t_refresh();
        int n;
        bit quiet = 1;
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'hCCCC);
        for (int k = 0; k < 5; k++) begin
            repeat (10) begin
                @(negedge clk);
                if (rst_req) quiet = 0;
            end
            wr(2'd0, 16'hAAAA);
        end
        check(quiet, "R5 no request while fed", quiet, 1);
        wait_pulse(2000, n);
        check(n == 16, "R5 timeout after last feed", n, 16);
    endtask

    task automatic t_no_stop();
        int n;
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h1234);
        wr(2'd0, 16'h5555);
        wait_pulse(2000, n);
        check(n == 9, "R8 keeps running after keys", n, 9);
        @(posedge clk);
        @(negedge clk);
        check(rst_req == 1'b0, "R9 request is one cycle", rst_req, 0);
        wait_pulse(2000, n);
        check(n + 1 == 12, "R9 periodic request", n + 1, 12);
    endtask

    task automatic t_zero();
        int n;
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd0);
        wr(2'd0, 16'hCCCC);
        wait_pulse(2000, n);
        check(n == 8, "R11 zero reload first tick", n, 8);
        wait_pulse(2000, n);
        check(n == 8, "R11 zero reload repeats", n, 8);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_idle();
        t_unlock_start();
        t_locked_writes();
        t_codes();
        t_other_key();
        t_refresh();
        t_no_stop();
        t_zero();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule